// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers inquire cycles that another bus master drives against a small physically tagged, direct-mapped cache whose lines follow MESI states. An inquire is one clock of the strobe `inq_strobe` with a cache-line address (physical bits 31..5) and an invalidate qualifier. Two clocks after the strobe is sampled, the block reports whether a valid line matched and whether that line held modified data. In the same clock it moves the line to invalid or shared. A modified match also issues a writeback request for the line.

The writeback request leaves the block on a valid/ready channel. `wb_valid_o` and `wb_line_o` stay fixed until `wb_ready_i` is sampled high. A later one-cycle `wb_done_i` marks the end of the writeback. A fill channel, also valid/ready, writes a tag and state into a line. The fill channel back-pressures while an inquire is in flight. Inquires may follow one another every second clock. A strobe that arrives too early, or while a writeback is outstanding, is dropped and reported on `inq_err_o`.

Top module: `snoop_responder`

## Requirements
- R1: After reset every line is invalid, `hit_o`, `hitm_o`, `wb_valid_o` and `inq_err_o` are 0, and `fill_ready_o` is 1.
- R2: For a strobe accepted at clock edge k, `hit_o`/`hitm_o` take the lookup result at edge k+2 and do not change at edge k+1. The line state update is applied at edge k+2.
- R3: The line index is `inq_line[5:0]` (address bits 10..5) and the tag is `inq_line[26:6]` (bits 31..11). `hit_o` becomes 1 when the indexed line is valid and its tag matches. Otherwise `hit_o` becomes 0, `hitm_o` stays 0 and no line changes. `hit_o` holds its value until the next result.
- R4: A match on a modified line (state code 3) sets both `hit_o` and `hitm_o`. At the same edge it raises `wb_valid_o` with `wb_line_o` equal to the inquire line address.
- R5: `wb_valid_o` and `wb_line_o` hold until `wb_ready_i` is sampled high, and then `wb_valid_o` falls. `hitm_o` stays 1 until `wb_done_i` is sampled high after that handshake, and falls at that edge. `wb_done_i` before the handshake is ignored.
- R6: With the invalidate qualifier high, a hit in any valid state moves the line to invalid, and a later inquire to it misses.
- R7: With the invalidate qualifier low, a hit on a shared, exclusive or modified line leaves it shared. A later inquire hits with `hitm_o` 0.
- R8: When the earlier inquire is not a modified hit, a strobe two edges after an accepted strobe is accepted and is answered two edges later.
- R9: A strobe is ignored, and `inq_err_o` pulses for one clock after it, in three cases. The first is one edge after an accepted strobe. The second is two edges after an accepted strobe whose lookup is a modified hit. The third is any edge while `hitm_o` is 1. A strobe sampled at the first edge where `hitm_o` reads 0 is accepted.
- R10: A fill writes the tag and state of the line addressed by `fill_line_i` when `fill_valid_i` and `fill_ready_o` are both high at an edge. The state codes are 0 invalid, 1 shared, 2 exclusive and 3 modified. `fill_ready_o` is 0 while an inquire is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inq_strobe | input | 1 | Inquire start strobe |
| inq_inval | input | 1 | Invalidate qualifier sampled with the strobe |
| inq_line | input | 27 | Inquire line address (physical bits 31..5) |
| hit_o | output | 1 | Valid line matched the last inquire |
| hitm_o | output | 1 | Matched line was modified; held until writeback done |
| inq_err_o | output | 1 | One-clock pulse: a strobe was dropped |
| wb_valid_o | output | 1 | Writeback request valid |
| wb_ready_i | input | 1 | Writeback request accepted |
| wb_line_o | output | 27 | Line address to write back |
| wb_done_i | input | 1 | Writeback finished |
| fill_valid_i | input | 1 | Fill request valid |
| fill_ready_o | output | 1 | Fill can be taken |
| fill_line_i | input | 27 | Line address to fill |
| fill_state_i | input | 2 | State code written by the fill |

## Verification
Every one of the 64 lines is filled with a distinct tag, and the four state codes rotate across the lines. Each line is then probed with a tag that differs by one bit, which separates a true compare from an index-only compare. It is also probed with the true tag under both qualifier settings, and probed again afterwards. That later probe shows at the ports whether the earlier inquire invalidated the line, demoted it, or left it alone. Timing patterns cover strobes one and two edges apart, strobes during an outstanding writeback, and the strobe right after the done edge. They tell a correct spacing rule apart from one that is too loose, which corrupts lines, or too strict, which drops legal inquires. The writeback channel is held back for several clocks and given an early done pulse, so the hold and ordering rules are exercised.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;
endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array
  import snp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_e         rd_st,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  line_st_e         fill_st,
  input  logic             upd_we,
  input  logic [IDX_W-1:0] upd_idx,
  input  line_st_e         upd_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  line_st_e         st_mem  [LINES];

  // tags need no reset: an invalid state masks them
  always_ff @(posedge clk) begin
    if (fill_we) tag_mem[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_mem[i] <= ST_I;
    end else if (fill_we) begin
      st_mem[fill_idx] <= fill_st;
    end else if (upd_we) begin
      st_mem[upd_idx] <= upd_st;
    end
  end

  assign rd_tag = tag_mem[rd_idx];
  assign rd_st  = st_mem[rd_idx];

  // R10: the fill port and the snoop update never compete
  a_r10_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && upd_we));
endmodule

// File: rtl/snp_wb_ctrl.sv
module snp_wb_ctrl #(
  parameter int LA_W = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LA_W-1:0] start_line,
  output logic            wb_valid,
  input  logic            wb_ready,
  output logic [LA_W-1:0] wb_line,
  input  logic            wb_done,
  output logic            pending
);
  typedef enum logic [1:0] {WB_IDLE, WB_REQ, WB_WAIT} wb_st_e;
  wb_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= WB_IDLE;
      wb_line <= '0;
    end else begin
      unique case (st_q)
        WB_IDLE: if (start) begin
          st_q    <= WB_REQ;
          wb_line <= start_line;
        end
        WB_REQ:  if (wb_ready) st_q <= WB_WAIT;
        WB_WAIT: if (wb_done)  st_q <= WB_IDLE;
        default: st_q <= WB_IDLE;
      endcase
    end
  end

  assign wb_valid = (st_q == WB_REQ);
  assign pending  = (st_q != WB_IDLE);

  // R5: request holds under back-pressure
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_line));
  // R9: no new writeback can start while one is outstanding
  a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pending);
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 5,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inq_strobe,
  input  logic                       inq_inval,
  input  logic [ADDR_W-LINE_LSB-1:0] inq_line,
  output logic                       hit_o,
  output logic                       hitm_o,
  output logic                       inq_err_o,
  output logic                       wb_valid_o,
  input  logic                       wb_ready_i,
  output logic [ADDR_W-LINE_LSB-1:0] wb_line_o,
  input  logic                       wb_done_i,
  input  logic                       fill_valid_i,
  output logic                       fill_ready_o,
  input  logic [ADDR_W-LINE_LSB-1:0] fill_line_i,
  input  logic [1:0]                 fill_state_i
);
  localparam int LA_W  = ADDR_W - LINE_LSB;
  localparam int TAG_W = LA_W - IDX_W;

  // stage 1: captured inquire
  logic            s1_v, s1_inv;
  logic [LA_W-1:0] s1_line;
  // stage 2: lookup result
  logic            s2_v, s2_inv, s2_hit, s2_mod;
  logic [LA_W-1:0] s2_line;
  logic            hit_q, err_q, wb_pend;

  logic [TAG_W-1:0] rd_tag;
  line_st_e         rd_st;
  logic             lk_hit, lk_mod;
  logic             busy, accept, fill_we, upd_we;
  line_st_e         upd_st;

  assign busy   = s1_v | (s2_v & s2_mod) | wb_pend;
  assign accept = inq_strobe & ~busy;

  assign lk_hit = (rd_st != ST_I) && (rd_tag == s1_line[LA_W-1:IDX_W]);
  assign lk_mod = lk_hit && (rd_st == ST_M);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_inv  <= 1'b0;
      s1_line <= '0;
      s2_v    <= 1'b0;
      s2_inv  <= 1'b0;
      s2_hit  <= 1'b0;
      s2_mod  <= 1'b0;
      s2_line <= '0;
      hit_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      s1_v  <= accept;
      err_q <= inq_strobe & busy;
      if (accept) begin
        s1_inv  <= inq_inval;
        s1_line <= inq_line;
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_inv  <= s1_inv;
        s2_hit  <= lk_hit;
        s2_mod  <= lk_mod;
        s2_line <= s1_line;
      end
      if (s2_v) hit_q <= s2_hit;
    end
  end

  assign upd_we  = s2_v & s2_hit;
  assign upd_st  = s2_inv ? ST_I : ST_S;
  assign fill_ready_o = ~s1_v & ~s2_v;
  assign fill_we = fill_valid_i & fill_ready_o;

  snp_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (s1_line[IDX_W-1:0]),
    .rd_tag   (rd_tag),
    .rd_st    (rd_st),
    .fill_we  (fill_we),
    .fill_idx (fill_line_i[IDX_W-1:0]),
    .fill_tag (fill_line_i[LA_W-1:IDX_W]),
    .fill_st  (line_st_e'(fill_state_i)),
    .upd_we   (upd_we),
    .upd_idx  (s2_line[IDX_W-1:0]),
    .upd_st   (upd_st)
  );

  snp_wb_ctrl #(.LA_W(LA_W)) u_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (s2_v & s2_mod),
    .start_line (s2_line),
    .wb_valid   (wb_valid_o),
    .wb_ready   (wb_ready_i),
    .wb_line    (wb_line_o),
    .wb_done    (wb_done_i),
    .pending    (wb_pend)
  );

  assign hit_o     = hit_q;
  assign hitm_o    = wb_pend;
  assign inq_err_o = err_q;

  // R4: a writeback request is only ever outstanding with hitm
  a_r4_req_with_hitm: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> hitm_o && hit_o);
  // R5: hitm only drops on a sampled done
  a_r5_hitm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hitm_o) |-> $past(wb_done_i));
  // R2: hit only moves when a lookup result retires
  a_r2_hit_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hit_o) |-> $past(s2_v));
  // R9: a strobe during a pending writeback starts nothing
  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    inq_strobe && hitm_o |=> !s1_v && inq_err_o);
endmodule

// File: tb/test_snoop_responder.sv
module test_snoop_responder;
  localparam int LA_W  = 27;
  localparam int IDX_W = 6;
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = LA_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inq_strobe = 1'b0, inq_inval = 1'b0;
  logic [LA_W-1:0] inq_line = '0;
  logic hit_o, hitm_o, inq_err_o, wb_valid_o, fill_ready_o;
  logic wb_ready_i = 1'b0, wb_done_i = 1'b0, fill_valid_i = 1'b0;
  logic [LA_W-1:0] wb_line_o;
  logic [LA_W-1:0] fill_line_i = '0;
  logic [1:0] fill_state_i = '0;

  int n_tests = 0, n_fail = 0;
  logic [TAG_W-1:0] m_tag [LINES];
  int m_st [LINES];

  always #10 clk = ~clk;

  snoop_responder i_snoop_responder (
    .clk(clk), .rst_n(rst_n), .inq_strobe(inq_strobe), .inq_inval(inq_inval),
    .inq_line(inq_line), .hit_o(hit_o), .hitm_o(hitm_o), .inq_err_o(inq_err_o),
    .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready_i), .wb_line_o(wb_line_o),
    .wb_done_i(wb_done_i), .fill_valid_i(fill_valid_i), .fill_ready_o(fill_ready_o),
    .fill_line_i(fill_line_i), .fill_state_i(fill_state_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LA_W-1:0] mk(input int idx, input logic [TAG_W-1:0] tag);
    return {tag, idx[IDX_W-1:0]};
  endfunction

  // called at a negedge, returns at a negedge
  task automatic fill(input int idx, input logic [TAG_W-1:0] tag, input int st);
    while (!fill_ready_o) @(negedge clk);
    fill_valid_i = 1'b1;
    fill_line_i  = mk(idx, tag);
    fill_state_i = st[1:0];
    @(negedge clk);
    fill_valid_i = 1'b0;
    m_tag[idx] = tag;
    m_st[idx]  = st;
  endtask

  // writeback with back-pressure and an early done; ends at negedge after hitm falls
  task automatic wb_handshake(input logic [LA_W-1:0] line);
    chk("R4 wb_valid", wb_valid_o, 1);
    chk("R4 wb_line", wb_line_o, line);
    wb_done_i = 1'b1;
    @(negedge clk);
    wb_done_i = 1'b0;
    chk("R5 early done ignored", hitm_o, 1);
    chk("R5 valid held", wb_valid_o, 1);
    @(negedge clk);
    chk("R5 line held", wb_line_o, line);
    wb_ready_i = 1'b1;
    @(negedge clk);
    wb_ready_i = 1'b0;
    chk("R5 valid drops", wb_valid_o, 0);
    chk("R5 hitm held", hitm_o, 1);
    @(negedge clk);
    chk("R5 hitm waits done", hitm_o, 1);
    wb_done_i = 1'b1;
    @(negedge clk);
    wb_done_i = 1'b0;
    chk("R5 hitm falls", hitm_o, 0);
  endtask

  // called at a negedge; handles writeback; updates model
  task automatic inquire(input logic [LA_W-1:0] line, input logic inv, input bit do_wb);
    int idx;
    bit eh, em;
    logic prev;
    idx = int'(line[IDX_W-1:0]);
    eh = (m_st[idx] != 0) && (m_tag[idx] == line[LA_W-1:IDX_W]);
    em = eh && (m_st[idx] == 3);
    prev = hit_o;
    inq_strobe = 1'b1; inq_inval = inv; inq_line = line;
    @(negedge clk);
    inq_strobe = 1'b0;
    chk("R10 fill_ready low in flight", fill_ready_o, 0);
    @(negedge clk);
    chk("R2 hit unchanged at k+1", hit_o, prev);
    chk("R2 hitm low at k+1", hitm_o, 0);
    @(negedge clk);
    chk(eh ? "R3 hit" : "R3 miss", hit_o, eh);
    chk(em ? "R4 hitm" : "R4 no hitm", hitm_o, em);
    if (eh) m_st[idx] = inv ? 0 : 1;
    if (em && do_wb) wb_handshake(line);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hit", hit_o, 0);
    chk("R1 hitm", hitm_o, 0);
    chk("R1 wb_valid", wb_valid_o, 0);
    chk("R1 err", inq_err_o, 0);
    chk("R1 fill_ready", fill_ready_o, 1);
    inquire(mk(9, 21'h0), 1'b0, 1'b1);   // R1: all lines invalid -> miss
    inquire(mk(63, 21'h1abcd), 1'b1, 1'b1);

    // R10: fill every line, states rotate 0..3
    for (int i = 0; i < LINES; i++) fill(i, TAG_W'(i * 37 + 5), i % 4);

    // sweep: R3 mismatch, R6/R7 action, observe afterwards
    for (int i = 0; i < LINES; i++) begin
      logic [TAG_W-1:0] t;
      logic inv;
      t = TAG_W'(i * 37 + 5);
      inv = i[2];
      inquire(mk(i, t ^ 21'h1), ~inv, 1'b1);   // R3 mismatch changes nothing
      inquire(mk(i, t), inv, 1'b1);            // R6 / R7 action
      inquire(mk(i, t), 1'b0, 1'b1);           // observe result of R6 / R7
    end

    // R8: two strobes two edges apart, first a shared hit
    fill(1, 21'h00111, 1);
    fill(2, 21'h00222, 1);
    inq_strobe = 1'b1; inq_inval = 1'b0; inq_line = mk(1, 21'h00111);
    @(negedge clk);
    inq_strobe = 1'b0;
    @(negedge clk);
    inq_strobe = 1'b1; inq_inval = 1'b0; inq_line = mk(2, 21'h00333);
    @(negedge clk);
    inq_strobe = 1'b0;
    chk("R8 first hit", hit_o, 1);
    chk("R8 no error", inq_err_o, 0);
    @(negedge clk);
    chk("R8 second not yet", hit_o, 1);
    chk("R8 no error 2", inq_err_o, 0);
    @(negedge clk);
    chk("R8 second answered miss", hit_o, 0);

    // R9: strobe one edge after an accepted one is dropped
    fill(3, 21'h00444, 1);
    inq_strobe = 1'b1; inq_inval = 1'b0; inq_line = mk(2, 21'h00222);
    @(negedge clk);
    inq_line = mk(3, 21'h00444); inq_inval = 1'b1;
    @(negedge clk);
    inq_strobe = 1'b0;
    chk("R9 err pulse back-to-back", inq_err_o, 1);
    @(negedge clk);
    chk("R9 err one clock", inq_err_o, 0);
    chk("R9 first still answered", hit_o, 1);
    repeat (2) @(negedge clk);
    chk("R9 no extra result", hit_o, 1);
    inquire(mk(3, 21'h00444), 1'b0, 1'b1);  // still hits: dropped strobe had no effect

    // R9: modified hit, strobe two edges later dropped, strobe while pending dropped
    fill(4, 21'h00555, 3);
    fill(5, 21'h00666, 1);
    inq_strobe = 1'b1; inq_inval = 1'b0; inq_line = mk(4, 21'h00555);
    @(negedge clk);
    inq_strobe = 1'b0;
    @(negedge clk);
    inq_strobe = 1'b1; inq_inval = 1'b1; inq_line = mk(5, 21'h00666);
    @(negedge clk);
    inq_strobe = 1'b0;
    chk("R4 hitm on modified", hitm_o, 1);
    chk("R9 err after modified lookahead", inq_err_o, 1);
    m_st[4] = 1;
    inq_strobe = 1'b1; inq_inval = 1'b1; inq_line = mk(5, 21'h00666);
    @(negedge clk);
    inq_strobe = 1'b0;
    chk("R9 err while pending", inq_err_o, 1);
    wb_handshake(mk(4, 21'h00555));
    // R9: strobe right at the first clock hitm reads 0 is accepted
    inquire(mk(5, 21'h00666), 1'b0, 1'b1);
    chk("R9 accepted no error", inq_err_o, 0);
    inquire(mk(4, 21'h00555), 1'b0, 1'b1);  // R7: modified demoted to shared

    // R6: modified line invalidated with writeback
    fill(6, 21'h00777, 3);
    inquire(mk(6, 21'h00777), 1'b1, 1'b1);
    inquire(mk(6, 21'h00777), 1'b0, 1'b1);  // now misses

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule